// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Controller

This block sits on a simple word-wide register bus and moves single characters between that bus and a pair of byte streams with valid/ready handshakes. Software reaches it through three word addresses. One holds the data word. One is a read-only status word. The third is a write-only command port. Writing the command port starts an operation on that same clock edge. A receive operation waits for the next incoming byte and stores it in the data word. A transmit operation sends the low byte of the data word, taking its value at the moment the command is written.

Every operation ends with a one-cycle interrupt pulse, and the status word is updated in the same cycle. This holds even when the command code was not recognised. A command written while another operation is still waiting abandons the older one, which never raises its interrupt, and starts the new one.

Top module: `char_term_ctrl`

## Requirements
- R1: One clock edge after a cycle with `rst` high, `irq`, `rx_ready` and `tx_valid` are low, and the data and status words read as zero.
- R2: A bus write to address 1 sets the data word. A read of address 1 returns it on `bus_rdata` one clock after the address is presented.
- R3: Address 0 (command) reads as zero. Bus writes to address 2 (status) leave the status word unchanged.
- R4: After a receive command (word value 1), `rx_ready` is high from the next cycle. When a byte is accepted (`rx_valid` and `rx_ready` both high at an edge), bits 7:0 of the data word take the byte and the upper bits are cleared. The status word becomes 0 (ok), `irq` is high for the following cycle and `rx_ready` falls.
- R5: While no receive is pending, `rx_ready` stays low. A byte offered then is not taken and the data word is unchanged.
- R6: After a transmit command (word value 2), `tx_valid` is high from the next cycle. `tx_data` equals bits 7:0 of the data word as it stood at the command write, and it holds until `tx_ready` is seen. The status word then becomes 0, with an `irq` pulse in the following cycle.
- R7: Data-word writes made after a transmit command do not change `tx_data` for that operation.
- R8: Any command word other than exactly 1 or 2 (all bits compared) raises `irq` in the cycle after the write and sets the status word to 1 (bad command). No handshake output is raised.
- R9: A command written while an operation is pending cancels it. No interrupt is produced for the cancelled operation, and the handshake outputs follow the new command from the next cycle.
- R10: If a command write coincides with a byte acceptance on the receive side, the command wins. The byte is discarded, the data word is unchanged and no interrupt is raised for the old receive.
- R11: `irq` is a single-cycle pulse for each completion.
- R12: If a bus write to the data word coincides with a byte acceptance, the received byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address (0 command, 1 data, 2 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| rx_valid | input | 1 | Incoming byte available |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Controller will take a byte this cycle |
| tx_valid | output | 1 | Outgoing byte available |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Sink takes the outgoing byte this cycle |
| irq | output | 1 | Completion pulse |

## Verification
Because `rx_ready` is registered, a command write and a byte acceptance on the receive side can share one clock edge. The bench provokes this by raising `rx_valid` together with a transmit command while a receive is waiting. It then judges the outcome: no interrupt, the data word keeps its preset value, and the transmit proceeds with that value. The second collision is a data-word bus write on the same edge as a received byte. The bench reads the data word back and expects the byte, with the upper bits zero.

// File: rtl/char_term_pkg.sv
package char_term_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_CMD  = 0;
  localparam int REG_DATA = 1;
  localparam int REG_STAT = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RX   = 2'd1,
    SEQ_TX   = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    STS_OK     = 2'd0,
    STS_BADCMD = 2'd1
  } sts_code_t;
endpackage

// File: rtl/cterm_seq.sv
module cterm_seq
  import char_term_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int unsigned CODE_RD = 1,
  parameter int unsigned CODE_WR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_code,
  input  logic [BYTE_W-1:0] data_lo,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              take_byte,
  output logic              fin,
  output sts_code_t         fin_sts,
  output logic              irq
);
  logic       is_rd, is_wr, bad_cmd, rx_fire, tx_fire;
  seq_state_t state_d;

  // The command port has priority: a command on the same edge as a
  // handshake cancels the old operation before it can complete.
  always_comb begin
    is_rd   = (cmd_code == DATA_W'(CODE_RD));
    is_wr   = (cmd_code == DATA_W'(CODE_WR));
    rx_fire = rx_ready && rx_valid && !cmd_we;
    tx_fire = tx_valid && tx_ready && !cmd_we;
    bad_cmd = cmd_we && !is_rd && !is_wr;
    fin     = bad_cmd || rx_fire || tx_fire;
    fin_sts = bad_cmd ? STS_BADCMD : STS_OK;
    if (rx_ready)      state_d = SEQ_RX;
    else if (tx_valid) state_d = SEQ_TX;
    else               state_d = SEQ_IDLE;
    if (cmd_we) begin
      if (is_rd)      state_d = SEQ_RX;
      else if (is_wr) state_d = SEQ_TX;
      else            state_d = SEQ_IDLE;
    end else if (rx_fire || tx_fire) begin
      state_d = SEQ_IDLE;
    end
  end

  assign take_byte = rx_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ready <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      irq      <= 1'b0;
    end else begin
      rx_ready <= (state_d == SEQ_RX);
      tx_valid <= (state_d == SEQ_TX);
      irq      <= fin;
      if (cmd_we && is_wr) tx_data <= data_lo;
    end
  end
endmodule

// File: rtl/cterm_regs.sv
module cterm_regs
  import char_term_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              take_byte,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              fin,
  input  sts_code_t         fin_sts,
  output logic [BYTE_W-1:0] data_lo,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int STS_W = $bits(sts_code_t);

  logic [DATA_W-1:0] data_q;
  sts_code_t         sts_q;

  // A received byte outranks a software write to the data word.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (take_byte) begin
      data_q <= {{(DATA_W-BYTE_W){1'b0}}, rx_data};
    end else if (bus_wr && bus_addr == ADDR_W'(REG_DATA)) begin
      data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      sts_q <= STS_OK;
    else if (fin) sts_q <= fin_sts;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(REG_DATA): bus_rdata <= data_q;
        ADDR_W'(REG_STAT): bus_rdata <= {{(DATA_W-STS_W){1'b0}}, sts_q};
        default:           bus_rdata <= '0;
      endcase
    end
  end

  assign data_lo = data_q[BYTE_W-1:0];
endmodule

// File: rtl/char_term_ctrl.sv
module char_term_ctrl
  import char_term_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 2,
  parameter int unsigned CODE_RD = 1,
  parameter int unsigned CODE_WR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  logic              cmd_we, take_byte, fin;
  sts_code_t         fin_sts;
  logic [BYTE_W-1:0] data_lo;

  assign cmd_we = bus_wr && (bus_addr == ADDR_W'(REG_CMD));

  cterm_seq #(.DATA_W(DATA_W), .CODE_RD(CODE_RD), .CODE_WR(CODE_WR)) u_seq (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(bus_wdata),
    .data_lo(data_lo), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .take_byte(take_byte), .fin(fin), .fin_sts(fin_sts), .irq(irq)
  );

  cterm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .take_byte(take_byte), .rx_data(rx_data),
    .fin(fin), .fin_sts(fin_sts), .data_lo(data_lo), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/char_term_chk.sv
module char_term_chk #(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 2,
  parameter int unsigned CODE_RD = 1,
  parameter int unsigned CODE_WR = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_ready,
  input logic              irq
);
  logic cmd_w, c_rd, c_wr;
  assign cmd_w = bus_wr && (bus_addr == '0);
  assign c_rd  = cmd_w && (bus_wdata == DATA_W'(CODE_RD));
  assign c_wr  = cmd_w && (bus_wdata == DATA_W'(CODE_WR));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && !rx_ready && !tx_valid));

  // R4
  rx_done_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && rx_valid && !cmd_w) |=> (irq && !rx_ready));

  // R5
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_ready && !cmd_w) |=> !rx_ready);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !cmd_w) |=> (tx_valid && $stable(tx_data)));

  // R8
  bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && !c_rd && !c_wr) |=> (irq && !rx_ready && !tx_valid));

  // R9
  new_rx_chk: assert property (@(posedge clk) disable iff (rst)
    c_rd |=> (rx_ready && !tx_valid && !irq));

  // R10
  new_tx_chk: assert property (@(posedge clk) disable iff (rst)
    c_wr |=> (tx_valid && !rx_ready && !irq));
endmodule

bind char_term_ctrl char_term_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_RD(CODE_RD), .CODE_WR(CODE_WR)
) u_chk (.*);

// File: tb/char_term_ctrl_bench.sv
module char_term_ctrl_bench;
  localparam int DW = 32;
  localparam logic [1:0] A_CMD = 2'd0, A_DAT = 2'd1, A_STS = 2'd2;
  localparam logic [31:0] C_RD = 32'd1, C_WR = 32'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 1'b0, rx_ready, tx_valid, tx_ready = 1'b0, irq;
  logic [7:0] rx_data = '0, tx_data;
  int n_tot = 0, n_bad = 0;

  always #10 clk = ~clk;

  char_term_ctrl u_char_term_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  // {preset[105:74], code[73:42], rx byte[41:34], kind[33:32], expect[31:0]}
  // kind 0 = receive, 1 = transmit, 2 = bad command
  localparam logic [105:0] VEC [7] = '{
    {32'h11223344, 32'h00000001, 8'hA5, 2'd0, 32'h000000A5},
    {32'h0000005A, 32'h00000002, 8'h00, 2'd1, 32'h0000005A},
    {32'hCAFEF00D, 32'h00000007, 8'h00, 2'd2, 32'hCAFEF00D},
    {32'hFFFFFFFF, 32'h00000001, 8'h00, 2'd0, 32'h00000000},
    {32'h123456FF, 32'h00000002, 8'h00, 2'd1, 32'h000000FF},
    {32'h00000000, 32'h00000000, 8'h00, 2'd2, 32'h00000000},
    {32'h00000000, 32'h00000101, 8'h00, 2'd2, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic run_all();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    rd(A_DAT, v); chk("R1 data", v, 0);
    rd(A_STS, v); chk("R1 status", v, 0);

    wr(A_DAT, 32'h89ABCDEF);
    rd(A_DAT, v); chk("R2 data readback", v, 32'h89ABCDEF);
    rd(A_CMD, v); chk("R3 command reads zero", v, 0);
    wr(A_STS, 32'hFFFFFFFF);
    rd(A_STS, v); chk("R3 status write ignored", v, 0);

    for (int i = 0; i < 7; i++) begin
      logic [105:0] e;
      e = VEC[i];
      wr(A_DAT, e[105:74]);
      wr(A_CMD, e[73:42]);
      case (e[33:32])
        2'd0: begin
          chk("R4 rx_ready up", 32'(rx_ready), 1);
          chk("R4 no early irq", 32'(irq), 0);
          rx_valid = 1'b1; rx_data = e[41:34];
          @(negedge clk);
          rx_valid = 1'b0;
          chk("R4 irq", 32'(irq), 1);
          chk("R4 rx_ready down", 32'(rx_ready), 0);
          rd(A_DAT, v); chk("R4 byte stored upper cleared", v, e[31:0]);
          chk("R11 irq single", 32'(irq), 0);
          rd(A_STS, v); chk("R4 status ok", v, 0);
        end
        2'd1: begin
          chk("R6 tx_valid", 32'(tx_valid), 1);
          chk("R6 tx_data", 32'(tx_data), e[31:0]);
          wr(A_DAT, ~e[105:74]);
          chk("R7 tx_data unchanged", 32'(tx_data), e[31:0]);
          chk("R6 tx still valid", 32'(tx_valid), 1);
          tx_ready = 1'b1;
          @(negedge clk);
          tx_ready = 1'b0;
          chk("R6 irq", 32'(irq), 1);
          chk("R6 tx_valid down", 32'(tx_valid), 0);
          rd(A_STS, v); chk("R6 status ok", v, 0);
          chk("R11 irq single", 32'(irq), 0);
        end
        default: begin
          chk("R8 irq", 32'(irq), 1);
          chk("R8 no handshake", {30'b0, rx_ready, tx_valid}, 0);
          rd(A_STS, v); chk("R8 status bad", v, 1);
          chk("R11 irq single", 32'(irq), 0);
          rd(A_DAT, v); chk("R8 data unchanged", v, e[31:0]);
        end
      endcase
    end

    // R5: offered byte while idle is not taken
    wr(A_DAT, 32'h00000077);
    rx_valid = 1'b1; rx_data = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R5 rx_ready low", 32'(rx_ready), 0);
    chk("R5 no irq", 32'(irq), 0);
    rd(A_DAT, v); chk("R5 data unchanged", v, 32'h77);
    wr(A_CMD, C_RD);
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R5 byte taken once pending", 32'(irq), 1);
    rd(A_DAT, v); chk("R5 data after read", v, 32'h3C);

    // R9: receive cancelled by transmit
    wr(A_DAT, 32'h000000C3);
    wr(A_CMD, C_RD);
    wr(A_CMD, C_WR);
    chk("R9 no irq for cancelled", 32'(irq), 0);
    chk("R9 rx_ready down", 32'(rx_ready), 0);
    chk("R9 tx_data", 32'(tx_data), 32'hC3);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    chk("R9 new op completes", 32'(irq), 1);

    // R9: pending receive cancelled by bad command, one pulse only
    wr(A_CMD, C_RD);
    wr(A_CMD, 32'h55);
    chk("R9 bad cancels irq", 32'(irq), 1);
    chk("R9 rx_ready after bad", 32'(rx_ready), 0);
    @(negedge clk);
    chk("R11 one pulse", 32'(irq), 0);

    // R10: command write on the same edge as a byte acceptance
    wr(A_DAT, 32'h00001234);
    wr(A_CMD, C_RD);
    rx_valid = 1'b1; rx_data = 8'hEE;
    wr(A_CMD, C_WR);
    rx_valid = 1'b0;
    chk("R10 no irq", 32'(irq), 0);
    chk("R10 tx started", 32'(tx_valid), 1);
    chk("R10 tx byte from data", 32'(tx_data), 32'h34);
    rd(A_DAT, v); chk("R10 byte discarded", v, 32'h1234);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    chk("R10 tx completes", 32'(irq), 1);

    // R12: data write on the same edge as a byte store
    wr(A_CMD, C_RD);
    rx_valid = 1'b1; rx_data = 8'h81;
    wr(A_DAT, 32'hDEADBEEF);
    rx_valid = 1'b0;
    chk("R12 irq", 32'(irq), 1);
    rd(A_DAT, v); chk("R12 byte wins", v, 32'h81);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        n_tot++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule